// File: doc/BRIEF.md
# Single-Cycle Integer Core for an Eight-Instruction RISC Subset

This block is a 32-bit processor core that completes one instruction on every clock edge. The subset it runs has three groups. The register-register operations are add, subtract, bitwise and, bitwise or and signed set-on-less-than. The memory operations are a word load and a word store. The last group is a branch taken when two registers are equal. The core holds the program counter and a 32-entry register file. Instruction and data storage sit outside the core, on two plain combinational read ports: a fetch port addressed by the program counter, and a data port with separate read and write strobes. A write on the data port lands at the next clock edge.

Each cycle the core decodes the fetched word, reads two source registers and computes a result in the ALU. It writes back either the ALU result or the loaded word, and moves the program counter. The counter moves either to the next sequential word or to a branch target. The target is the sequential address plus the sign-extended 16-bit offset scaled by four. The branch decision is the decoded branch flag ANDed with the ALU zero flag, after the ALU subtracts the two operands.

Instruction fields: opcode [31:26], first source [25:21], second source or load destination [20:16], register-register destination [15:11], shift amount [10:6], function code [5:0], immediate [15:0]. Opcodes: 0x00 register-register, 0x23 load word, 0x2B store word, 0x04 branch-if-equal. Function codes with opcode 0x00: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A set-less-than.

Top module: `scc_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 (asynchronous). The first instruction fetched after release is at address 0.
- R2: After any instruction other than a taken branch, `imem_addr` becomes the previous address plus 4. `imem_addr[1:0]` is always 0.
- R3: Opcode 0x04 with equal source registers sets the next address to the current address + 4 + (sign-extended immediate << 2). With unequal sources it falls through to address + 4, and the skipped instructions have no effect.
- R4: Opcode 0x00 with function 0x20/0x22/0x24/0x25/0x2A writes register [15:11] with the sum, the difference (first minus second), the AND, the OR, or 1/0 for a signed first < second.
- R5: Opcode 0x23 raises `dmem_re`, drives `dmem_addr` = first source + sign-extended immediate, and writes the returned `dmem_rdata` to register [20:16].
- R6: Opcode 0x2B raises `dmem_we`, drives `dmem_addr` = first source + sign-extended immediate and `dmem_wdata` = register [20:16], and writes no register.
- R7: Register 0 reads as zero. A write aimed at it is dropped.
- R8: `dmem_re` and `dmem_we` are never high together, and each is high only for its own opcode.
- R9: Any other opcode, a function code outside the five, or a register-register word with a nonzero shift amount writes no register and no memory, and the core advances by 4.
- R10: A negative immediate (bit 15 set) is sign-extended for both memory addressing and backward branch targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_re | output | 1 | Load strobe |
| dmem_we | output | 1 | Store strobe, written at the next rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, valid in the same cycle |

## Verification
The assertions assume three things about the environment. `imem_rdata` is a known word in every cycle after reset. Both memories answer combinationally within the cycle. The program never relies on register contents it has not yet written, since the register file has no reset. The stimulus keeps to these by filling the whole instruction memory model, where an all-zero word decodes as an unsupported function and does nothing. The program starts by loading its operands from preset data words. It then ends in a backward self-branch, so the fetch address never leaves the modelled range.

// File: rtl/scc_pkg.sv
package scc_pkg;

  localparam logic [5:0] OP_RR  = 6'h00;
  localparam logic [5:0] OP_LD  = 6'h23;
  localparam logic [5:0] OP_ST  = 6'h2B;
  localparam logic [5:0] OP_BEQ = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_fn_e;

  typedef enum logic [1:0] {
    ACLS_ADD,
    ACLS_SUB,
    ACLS_FUNCT
  } alu_cls_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    opb_imm;
    logic    mem_rd;
    logic    mem_wr;
    logic    wb_from_mem;
    logic    branch;
    alu_fn_e alu_fn;
  } ctrl_t;

endpackage

// File: rtl/scc_decode.sv
module scc_decode
  import scc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  alu_cls_e cls;
  logic     main_ok;
  logic     fn_ok;
  alu_fn_e  fn_sel;
  ctrl_t    base;

  // Main decode: data-path steering from the opcode alone.
  always_comb begin
    base    = '0;
    cls     = ACLS_ADD;
    main_ok = 1'b1;
    unique case (opcode)
      OP_RR: begin
        base.reg_we    = 1'b1;
        base.dst_is_rd = 1'b1;
        cls            = ACLS_FUNCT;
      end
      OP_LD: begin
        base.reg_we      = 1'b1;
        base.opb_imm     = 1'b1;
        base.mem_rd      = 1'b1;
        base.wb_from_mem = 1'b1;
      end
      OP_ST: begin
        base.opb_imm = 1'b1;
        base.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        base.branch = 1'b1;
        cls         = ACLS_SUB;
      end
      default: main_ok = 1'b0;
    endcase
  end

  // ALU decode: class from the main decoder refined by the function code.
  always_comb begin
    fn_ok  = 1'b1;
    fn_sel = ALU_ADD;
    unique case (cls)
      ACLS_ADD: fn_sel = ALU_ADD;
      ACLS_SUB: fn_sel = ALU_SUB;
      default: begin
        fn_ok = (shamt == 5'd0);
        unique case (funct)
          FN_ADD:  fn_sel = ALU_ADD;
          FN_SUB:  fn_sel = ALU_SUB;
          FN_AND:  fn_sel = ALU_AND;
          FN_OR:   fn_sel = ALU_OR;
          FN_SLT:  fn_sel = ALU_SLT;
          default: fn_ok  = 1'b0;
        endcase
      end
    endcase
  end

  always_comb begin
    if (main_ok && fn_ok) begin
      ctrl        = base;
      ctrl.alu_fn = fn_sel;
    end else begin
      ctrl = '0;
    end
  end

endmodule

// File: rtl/scc_regfile.sv
module scc_regfile #(
  parameter int WIDTH = 32,
  parameter int NREGS = 32,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic [IDXW-1:0]  ra_a,
  input  logic [IDXW-1:0]  ra_b,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_b
);

  logic [WIDTH-1:0] view [NREGS];

  assign view[0] = '0;

  for (genvar i = 1; i < NREGS; i++) begin : g_ent
    logic             ld;
    logic [WIDTH-1:0] q;
    assign ld = wr_en && (wr_idx == IDXW'(i));
    always_ff @(posedge clk) begin
      if (ld) begin
        q <= wr_data;
      end
    end
    assign view[i] = q;
  end

  assign rd_a = view[ra_a];
  assign rd_b = view[ra_b];

endmodule

// File: rtl/scc_alu.sv
module scc_alu
  import scc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  alu_fn_e          fn,
  output logic [WIDTH-1:0] res,
  output logic             zero
);

  always_comb begin
    unique case (fn)
      ALU_SUB: res = opa - opb;
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      ALU_SLT: res = {{(WIDTH-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: res = opa + opb;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/scc_core.sv
module scc_core
  import scc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_re,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int IDXW   = $clog2(NREGS);
  localparam int IMMW   = 16;
  localparam int STEP   = 4;
  localparam int WSHIFT = 2;

  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] pc_seq, pc_tgt;
  logic [XLEN-1:0] imm_ext, br_off;
  logic [XLEN-1:0] src_a, src_b, opb, alu_y, wb_data;
  logic [IDXW-1:0] dst_idx;
  logic            alu_zero, take;
  ctrl_t           ctrl;

  logic [5:0]      f_op, f_fn;
  logic [4:0]      f_rs, f_rt, f_rd, f_sh;
  logic [IMMW-1:0] f_imm;

  assign f_op  = imem_rdata[31:26];
  assign f_rs  = imem_rdata[25:21];
  assign f_rt  = imem_rdata[20:16];
  assign f_rd  = imem_rdata[15:11];
  assign f_sh  = imem_rdata[10:6];
  assign f_fn  = imem_rdata[5:0];
  assign f_imm = imem_rdata[15:0];

  scc_decode u_dec (
    .opcode (f_op),
    .shamt  (f_sh),
    .funct  (f_fn),
    .ctrl   (ctrl)
  );

  assign dst_idx = ctrl.dst_is_rd ? IDXW'(f_rd) : IDXW'(f_rt);
  assign wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;

  scc_regfile #(.WIDTH(XLEN), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .ra_a    (IDXW'(f_rs)),
    .ra_b    (IDXW'(f_rt)),
    .wr_en   (ctrl.reg_we),
    .wr_idx  (dst_idx),
    .wr_data (wb_data),
    .rd_a    (src_a),
    .rd_b    (src_b)
  );

  assign imm_ext = {{(XLEN-IMMW){f_imm[IMMW-1]}}, f_imm};
  assign opb     = ctrl.opb_imm ? imm_ext : src_b;

  scc_alu #(.WIDTH(XLEN)) u_alu (
    .opa  (src_a),
    .opb  (opb),
    .fn   (ctrl.alu_fn),
    .res  (alu_y),
    .zero (alu_zero)
  );

  // Next-state logic for the program counter.
  assign br_off = imm_ext << WSHIFT;
  assign pc_seq = pc_q + XLEN'(STEP);
  assign pc_tgt = pc_seq + br_off;
  assign take   = ctrl.branch & alu_zero;

  always_comb begin
    pc_d = take ? pc_tgt : pc_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = src_b;
  assign dmem_re    = ctrl.mem_rd;
  assign dmem_we    = ctrl.mem_wr;

endmodule

// File: rtl/scc_core_chk.sv
module scc_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic [XLEN-1:0] imem_rdata,
  input logic            dmem_re,
  input logic            dmem_we
);

  localparam logic [5:0] C_LD  = 6'h23;
  localparam logic [5:0] C_ST  = 6'h2B;
  localparam logic [5:0] C_BEQ = 6'h04;
  localparam logic [5:0] C_RR  = 6'h00;

  logic [5:0]      op;
  logic [XLEN-1:0] boff;

  assign op   = imem_rdata[31:26];
  assign boff = {{(XLEN-18){imem_rdata[15]}}, imem_rdata[15:0], 2'b00};

  assert_fetch_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> imem_addr == '0);

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op != C_BEQ) |=> imem_addr == $past(imem_addr) + XLEN'(4));

  assert_branch_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == C_BEQ) |=> (imem_addr == $past(imem_addr) + XLEN'(4)) ||
                      (imem_addr == $past(imem_addr) + XLEN'(4) + $past(boff)));

  assert_load_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |-> op == C_LD);

  assert_store_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> op == C_ST);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_re && dmem_we));

  assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op != C_LD && op != C_ST && op != C_BEQ && op != C_RR) |-> !dmem_re && !dmem_we);

endmodule

bind scc_core scc_core_chk #(.XLEN(XLEN)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_re    (dmem_re),
  .dmem_we    (dmem_we)
);

// File: tb/test_scc_core.sv
module test_scc_core;

  localparam int CLK_PERIOD = 10;
  localparam int MWORDS     = 64;
  localparam int NVEC       = 26;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_re, dmem_we;

  logic [31:0] imem [MWORDS];
  logic [31:0] dmem [MWORDS];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scc_core i_scc_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  // Memory models: combinational read, write at the rising edge.
  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] rr(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] im(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // Vector: {pc, re, we, addr, wdata}
  function automatic logic [97:0] v(logic [31:0] pc, logic re, logic we,
                                    logic [31:0] a, logic [31:0] d);
    return {pc, re, we, a, d};
  endfunction

  localparam logic [97:0] VEC [NVEC] = '{
    v(0,   1, 0, 0,  0),           v(4,   1, 0, 4,  0),
    v(8,   0, 0, 0,  0),           v(12,  0, 0, 0,  0),
    v(16,  0, 0, 0,  0),           v(20,  0, 0, 0,  0),
    v(24,  0, 0, 0,  0),           v(28,  0, 0, 0,  0),
    v(32,  0, 1, 16, 32'h4),       v(36,  0, 1, 20, 32'hA),
    v(40,  0, 1, 24, 32'h5),       v(44,  0, 1, 28, 32'hFFFF_FFFF),
    v(48,  0, 1, 32, 32'h1),       v(52,  0, 1, 36, 32'h0),
    v(56,  0, 0, 0,  0),           v(60,  0, 1, 40, 32'h0),
    v(64,  0, 0, 0,  0),           v(68,  0, 0, 0,  0),
    v(80,  1, 0, 0,  0),           v(84,  0, 1, 48, 32'h7),
    v(88,  0, 0, 0,  0),           v(92,  0, 0, 0,  0),
    v(96,  0, 1, 52, 32'h7),       v(100, 0, 0, 0,  0),
    v(108, 0, 0, 0,  0),           v(108, 0, 0, 0,  0)
  };

  function automatic string tag_of(int k);
    case (k)
      0, 1:           return "R5 load";
      2, 3, 4, 5, 6, 7: return "R4 reg-reg";
      8, 9, 10, 11, 12, 13: return "R6 store/R4 result";
      14, 15:         return "R7 zero register";
      16, 17:         return "R3 branch";
      18, 19:         return "R10 negative offset";
      20, 21, 22:     return "R9 unsupported";
      default:        return "R3 backward branch/R10";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < MWORDS; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    dmem[0] = 32'h0000_0007;
    dmem[1] = 32'hFFFF_FFFD;

    imem[0]  = im(6'h23, 0, 1, 16'd0);          // r1 = 7
    imem[1]  = im(6'h23, 0, 2, 16'd4);          // r2 = -3
    imem[2]  = rr(1, 2, 3, 6'h20);              // r3 = 4
    imem[3]  = rr(1, 2, 4, 6'h22);              // r4 = 10
    imem[4]  = rr(1, 2, 5, 6'h24);              // r5 = 5
    imem[5]  = rr(1, 2, 6, 6'h25);              // r6 = -1
    imem[6]  = rr(2, 1, 7, 6'h2A);              // r7 = 1
    imem[7]  = rr(1, 2, 8, 6'h2A);              // r8 = 0
    imem[8]  = im(6'h2B, 0, 3, 16'd16);
    imem[9]  = im(6'h2B, 0, 4, 16'd20);
    imem[10] = im(6'h2B, 0, 5, 16'd24);
    imem[11] = im(6'h2B, 0, 6, 16'd28);
    imem[12] = im(6'h2B, 0, 7, 16'd32);
    imem[13] = im(6'h2B, 0, 8, 16'd36);
    imem[14] = rr(1, 1, 0, 6'h20);              // write to r0 dropped
    imem[15] = im(6'h2B, 0, 0, 16'd40);
    imem[16] = im(6'h04, 1, 2, 16'd5);          // not taken
    imem[17] = im(6'h04, 7, 7, 16'd2);          // taken to 80
    imem[18] = im(6'h2B, 0, 1, 16'd44);         // skipped
    imem[19] = im(6'h2B, 0, 1, 16'd44);         // skipped
    imem[20] = im(6'h23, 3, 9, 16'hFFFC);       // r9 = mem[0] = 7
    imem[21] = im(6'h2B, 3, 9, 16'd44);         // mem[48] = 7
    imem[22] = im(6'h3F, 1, 9, 16'h0010);       // unknown opcode
    imem[23] = rr(1, 2, 9, 6'h27);              // unknown function
    imem[24] = im(6'h2B, 0, 9, 16'd52);         // r9 still 7
    imem[25] = im(6'h04, 0, 0, 16'd1);          // to 108
    imem[26] = im(6'h2B, 0, 1, 16'd56);         // skipped
    imem[27] = im(6'h04, 0, 0, 16'hFFFF);       // self loop

    repeat (3) @(negedge clk);
    #1;
    check(imem_addr == 32'h0, "R1 reset pc", imem_addr, 0);
    check(!dmem_we, "R1 no store in reset", dmem_we, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      #1;
      begin
        logic [97:0] e;
        bit ok;
        e  = VEC[k];
        ok = (imem_addr == e[97:66]) && (dmem_re == e[65]) && (dmem_we == e[64]);
        if (e[65] || e[64]) ok = ok && (dmem_addr == e[63:32]);
        if (e[64])          ok = ok && (dmem_wdata == e[31:0]);
        check(ok, tag_of(k),
              {imem_addr, dmem_re, dmem_we, dmem_addr, dmem_wdata}, e);
      end
      @(negedge clk);
    end

    #1;
    check(dmem[11] == 32'h0, "R3 skipped store left memory", dmem[11], 0);
    check(dmem[12] == 32'h7, "R10 negative-offset load value", dmem[12], 7);
    check(dmem[14] == 32'h0, "R3 backward branch skipped store", dmem[14], 0);

    rst_n = 1'b0;
    #1;
    check(imem_addr == 32'h0, "R1 async reset mid-run", imem_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(imem_addr == 32'h0, "R1 first fetch after release", imem_addr, 0);
    @(negedge clk);
    #1;
    check(imem_addr == 32'h4, "R2 sequential step", imem_addr, 4);

    finish_run();
  end

endmodule